// File: doc/BRIEF.md
# Five-Operand Sign-Controlled Summation Stage

This block is the last arithmetic stage of a multiplier that shares computation across the taps of an FIR filter. Five unsigned partial products of width N arrive together. A carry-save compressor tree in the Wallace style reduces them to two vectors. A look-ahead adder then merges those two vectors into one unsigned magnitude of N+3 bits. Five maximal operands cannot overflow that width.

The sign of the product comes from two separate bits: the sign bit of the coefficient and the sign bit of the data sample. Their exclusive-OR selects the polarity. An XOR array inverts every bit of the widened magnitude under that control, and a +1 injected at the least significant bit completes the two's-complement negation. The result is an N+4 bit signed value.

A parameter decides whether this value leaves through a register or directly from the logic. The register has a synchronous, active-high clear.

Top module: `sgn_sum5`

## Requirements
- R1: When `coef_sign` equals `data_sign`, the result equals the zero-extended sum of the five operands.
- R2: When `coef_sign` differs from `data_sign`, the result equals the two's-complement negative of that sum, in N+4 bits.
- R3: All five operands at 2^N-1 give 5*(2^N-1) with equal signs and its negative with differing signs, with no wrap.
- R4: With `REG_OUT`=1 the result reflects the inputs sampled at the previous rising edge of `clk`. With `REG_OUT`=0 it follows the inputs with no clock.
- R5: With `REG_OUT`=1, `rst` high at a rising edge clears the result to zero, whatever the operands are.
- R6: All-zero operands give a result of zero for all four sign-bit pairs. Negating zero gives zero.
- R7: The top bit of the result (bit N+3) is 1 exactly when the sign bits differ and the operand sum is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high clear of the output register |
| op0 | input | N | Partial product 0, unsigned |
| op1 | input | N | Partial product 1, unsigned |
| op2 | input | N | Partial product 2, unsigned |
| op3 | input | N | Partial product 3, unsigned |
| op4 | input | N | Partial product 4, unsigned |
| coef_sign | input | 1 | Sign bit of the coefficient |
| data_sign | input | 1 | Sign bit of the data sample |
| result | output | N+4 | Signed sum, two's complement |

## Verification
The assertions assume that every input is a defined value that does not change between the falling edge, where it is set, and the next rising edge. They also assume that operands are plain unsigned magnitudes with no sign information in them. The bench meets these assumptions by changing inputs only at falling edges and by drawing every operand from the full unsigned range N. It also covers the extremes, all zero and all ones, under each of the four sign pairs. A clear is raised in the middle of traffic while the operands are nonzero.

// File: rtl/sgn_sum5.sv
module sgn_sum5 #(
  parameter int N       = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N-1:0]        op0,
  input  logic [N-1:0]        op1,
  input  logic [N-1:0]        op2,
  input  logic [N-1:0]        op3,
  input  logic [N-1:0]        op4,
  input  logic                coef_sign,
  input  logic                data_sign,
  output logic signed [N+3:0] result
);
  localparam int W  = N + 3;
  localparam int O  = N + 4;
  localparam int NG = (W + 3) / 4;
  localparam int WP = 4 * NG;

  logic [W-1:0] x0, x1, x2, x3, x4;
  assign x0 = W'(op0);
  assign x1 = W'(op1);
  assign x2 = W'(op2);
  assign x3 = W'(op3);
  assign x4 = W'(op4);

  logic [W-1:0] s1, c1, s2, c2, s3, c3;
  assign s1 = x0 ^ x1 ^ x2;
  assign c1 = ((x0 & x1) | (x0 & x2) | (x1 & x2)) << 1;
  assign s2 = s1 ^ c1 ^ x3;
  assign c2 = ((s1 & c1) | (s1 & x3) | (c1 & x3)) << 1;
  assign s3 = s2 ^ c2 ^ x4;
  assign c3 = ((s2 & c2) | (s2 & x4) | (c2 & x4)) << 1;

  logic [WP-1:0] pa, pb, gb, pbt, cb, sb;
  logic [NG:0]   gc;
  assign pa    = WP'(s3);
  assign pb    = WP'(c3);
  assign gb    = pa & pb;
  assign pbt   = pa ^ pb;
  assign gc[0] = 1'b0;

  for (genvar k = 0; k < NG; k++) begin : g_cla
    logic [3:0] g, p;
    logic       ci, gg, gp;
    assign g  = gb[4*k +: 4];
    assign p  = pbt[4*k +: 4];
    assign ci = gc[k];
    assign cb[4*k]   = ci;
    assign cb[4*k+1] = g[0] | (p[0] & ci);
    assign cb[4*k+2] = g[1] | (p[1] & g[0]) | (p[1] & p[0] & ci);
    assign cb[4*k+3] = g[2] | (p[2] & g[1]) | (p[2] & p[1] & g[0])
                     | (p[2] & p[1] & p[0] & ci);
    assign gg = g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1])
              | (p[3] & p[2] & p[1] & g[0]);
    assign gp = &p;
    assign gc[k+1] = gg | (gp & ci);
  end
  assign sb = pbt ^ cb;

  logic         neg;
  logic [O-1:0] mag, inv, res;
  logic [O:0]   inc;
  assign neg    = coef_sign ^ data_sign;
  assign mag    = {1'b0, sb[W-1:0]};
  assign inv    = mag ^ {O{neg}};
  assign inc[0] = neg;
  for (genvar i = 0; i < O; i++) begin : g_inc
    assign inc[i+1] = inc[i] & inv[i];
  end
  assign res = inv ^ inc[O-1:0];

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) result <= '0;
      else     result <= $signed(res);
    end
  end else begin : g_comb
    assign result = $signed(res);
  end
endmodule

module sgn_sum5_chk #(
  parameter int N       = 16,
  parameter bit REG_OUT = 1'b1
) (
  input logic                clk,
  input logic                rst,
  input logic [N-1:0]        op0,
  input logic [N-1:0]        op1,
  input logic [N-1:0]        op2,
  input logic [N-1:0]        op3,
  input logic [N-1:0]        op4,
  input logic                coef_sign,
  input logic                data_sign,
  input logic signed [N+3:0] result
);
  logic [N+3:0] tot;
  assign tot = (N+4)'(op0) + (N+4)'(op1) + (N+4)'(op2) + (N+4)'(op3) + (N+4)'(op4);

  if (REG_OUT) begin : g_props
    // R1
    pass_sum_chk: assert property (@(posedge clk) disable iff (rst)
      (coef_sign == data_sign) |=> (result == $signed($past(tot))));
    // R2
    neg_sum_chk: assert property (@(posedge clk) disable iff (rst)
      (coef_sign != data_sign) |=> (result == -$signed($past(tot))));
    // R5
    rst_clear_chk: assert property (@(posedge clk) rst |=> (result == '0));
    // R6
    zero_in_chk: assert property (@(posedge clk) disable iff (rst)
      (tot == '0) |=> (result == '0));
    // R7
    sign_bit_chk: assert property (@(posedge clk) disable iff (rst)
      (tot != '0) |=> (result[N+3] == $past(coef_sign ^ data_sign)));
  end
endmodule

bind sgn_sum5 sgn_sum5_chk #(.N(N), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst(rst), .op0(op0), .op1(op1), .op2(op2), .op3(op3), .op4(op4),
  .coef_sign(coef_sign), .data_sign(data_sign), .result(result));

// File: tb/test_sgn_sum5.sv
module test_sgn_sum5;
  localparam int N = 16;
  localparam int O = N + 4;

  typedef struct {
    logic signed [O-1:0] exp;
    logic                neg;
    int                  req;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] a = '0, b = '0, c = '0, d = '0, e = '0;
  logic cs = 1'b0, ds = 1'b0;
  logic signed [O-1:0] res_q, res_c;
  logic signed [O-1:0] prev_exp = '0;
  item_t q[$];
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sgn_sum5 #(.N(N), .REG_OUT(1'b1)) i_sgn_sum5 (
    .clk(clk), .rst(rst), .op0(a), .op1(b), .op2(c), .op3(d), .op4(e),
    .coef_sign(cs), .data_sign(ds), .result(res_q));

  sgn_sum5 #(.N(N), .REG_OUT(1'b0)) i_sgn_sum5_comb (
    .clk(clk), .rst(rst), .op0(a), .op1(b), .op2(c), .op3(d), .op4(e),
    .coef_sign(cs), .data_sign(ds), .result(res_c));

  task automatic check(input bit ok, input int req, input logic signed [O-1:0] act,
                       input logic signed [O-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL R%0d actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic [N-1:0] va, vb, vc, vd, ve,
                       input logic vcs, vds, input int req, input bit vr);
    logic [O-1:0] m;
    logic signed [O-1:0] x, xc;
    item_t it;
    @(negedge clk);
    a = va; b = vb; c = vc; d = vd; e = ve; cs = vcs; ds = vds; rst = vr;
    m  = O'(va) + O'(vb) + O'(vc) + O'(vd) + O'(ve);
    xc = (vcs ^ vds) ? -$signed(m) : $signed(m);
    x  = vr ? '0 : xc;
    it.exp = x; it.neg = (vcs ^ vds) && (m != 0) && !vr; it.req = req;
    q.push_back(it);
    #1;
    // R4: combinational variant follows at once, registered one holds old value
    check(res_c == xc, 4, res_c, xc);
    check(res_q == prev_exp, 4, res_q, prev_exp);
    prev_exp = x;
  endtask

  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      check(res_q == it.exp, it.req, res_q, it.exp);
      // R7: sign bit of the output
      check(res_q[O-1] == it.neg, 7, res_q, it.exp);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R5: reset state
    check(res_q == '0, 5, res_q, '0);
    @(negedge clk); rst = 1'b0;
    // R6: zero operands under each sign pair
    for (int s = 0; s < 4; s++)
      drive('0, '0, '0, '0, '0, s[1], s[0], 6, 1'b0);
    // R3: all operands at maximum under each sign pair
    for (int s = 0; s < 4; s++)
      drive('1, '1, '1, '1, '1, s[1], s[0], 3, 1'b0);
    // R1 and R2: single operand and random vectors
    drive(16'd1, '0, '0, '0, '0, 1'b0, 1'b0, 1, 1'b0);
    drive('0, '0, '0, '0, 16'd1, 1'b1, 1'b0, 2, 1'b0);
    for (int i = 0; i < 300; i++) begin
      logic vcs, vds;
      vcs = 1'($urandom); vds = 1'($urandom);
      drive(N'($urandom), N'($urandom), N'($urandom), N'($urandom), N'($urandom),
            vcs, vds, (vcs ^ vds) ? 2 : 1, 1'b0);
    end
    // R5: clear with nonzero operands mid-stream
    drive('1, 16'd7, 16'd99, '1, 16'd3, 1'b1, 1'b0, 5, 1'b1);
    drive(16'd5, 16'd6, 16'd7, 16'd8, 16'd9, 1'b0, 1'b1, 2, 1'b0);
    repeat (3) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      total++; bad++;
      $display("FAIL R4 actual=hung expected=completion");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule